// File: doc/BRIEF.md
# Warp-Aware Write Drain Mode Controller

This block decides, once per cycle, which kind of traffic one memory channel serves. It reads the occupancy of the channel's write queue and a flag that says whether any read warp-group made of exactly one request is waiting. From these two inputs it selects one of three modes. In normal read mode, every read group may be scheduled. In singleton mode, only one-request read groups may be scheduled. In full drain mode, the queued writes are sent out as a batch.

Singleton mode covers an occupancy band below the level that starts a full drain. Inside this band, small warp-groups can still finish before a write burst holds the channel. Groups that need many requests are held back, because they could not complete before the drain would stall them. A full drain continues until occupancy falls to a low mark, so the channel does not switch modes back and forth. The transaction scheduler uses the registered outputs to filter its read candidates and to start write issue.

The states are READ, SINGLETON and DRAIN. The transitions are:
- READ_TO_SINGLETON: occupancy is at or above the restrict mark and below the high mark.
- READ_TO_DRAIN and SINGLETON_TO_DRAIN: occupancy is at or above the high mark.
- SINGLETON_TO_READ: occupancy is below the restrict mark.
- DRAIN_TO_READ: occupancy is at or below the low mark.

Every other case holds the current state.

Top module: `wdrain_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the outputs are: `mode_o` = 0 (READ), `drain_writes` = 0, `singleton_only` = 0, `read_enable` = 1.
- R2: From READ or SINGLETON, an occupancy at or above HIGH_MARK (default 56) sampled at a rising edge puts the block in DRAIN after that edge: `mode_o` = 2, `drain_writes` = 1.
- R3: In DRAIN, the block stays in DRAIN while the sampled occupancy is above LOW_MARK (default 16). This holds even when the occupancy is inside the restrict band. An occupancy at or below LOW_MARK moves the block directly to READ (`mode_o` = 0).
- R4: From READ, an occupancy in the range RESTRICT_MARK (default 40) to HIGH_MARK-1 moves the block to SINGLETON (`mode_o` = 1, `singleton_only` = 1). From SINGLETON, an occupancy below RESTRICT_MARK moves it back to READ.
- R5: Whenever `drain_writes` is 1, `read_enable` is 0.
- R6: In SINGLETON, `read_enable` equals the value of `single_grp_pending` sampled at the same edge that produced the state. In READ, `read_enable` is 1 and `single_grp_pending` has no effect on it.
- R7: `drain_writes` and `singleton_only` are never 1 at the same time. `mode_o` encodes READ as 0, SINGLETON as 1 and DRAIN as 2, and it never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the block samples its inputs on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wq_count | input | 7 | Write-queue occupancy, range 0 to DEPTH |
| single_grp_pending | input | 1 | High when at least one read warp-group with a single request is waiting |
| mode_o | output | 2 | Current mode: 0 = READ, 1 = SINGLETON, 2 = DRAIN |
| drain_writes | output | 1 | High when the channel should issue queued writes as a batch |
| singleton_only | output | 1 | High when reads are limited to one-request groups |
| read_enable | output | 1 | High when the scheduler may issue reads in this cycle |

## Verification
The bench drives the occupancy exactly onto each mark and one step below it.

- **Off-by-one at a mark.** A design that compares with the wrong inequality at the restrict, high or low mark would enter or leave a mode one count too early or too late.
- **No hysteresis in DRAIN.** The bench lowers the occupancy from DRAIN into the restrict band. A design that ends the drain there would fall into SINGLETON instead of staying in DRAIN.
- **Pending flag mishandled.** The bench varies `single_grp_pending` in all three modes. A design that ignores the flag in SINGLETON, or lets it gate reads in READ, would show a wrong `read_enable`.
- **Reset in the middle of a drain.** The bench asserts reset while DRAIN is active. A design whose reset does not clear the output registers would still report a drain.

// File: rtl/wdrain_pkg.sv
package wdrain_pkg;

    typedef enum logic [1:0] {
        MODE_READ      = 2'd0,
        MODE_SINGLETON = 2'd1,
        MODE_DRAIN     = 2'd2
    } wd_mode_e;

    typedef struct packed {
        logic at_high;
        logic at_restrict;
        logic at_or_below_low;
    } wd_level_t;

endpackage

// File: rtl/wdrain_level_cmp.sv
module wdrain_level_cmp
    import wdrain_pkg::*;
#(
    parameter int DEPTH         = 64,
    parameter int LOW_MARK      = 16,
    parameter int RESTRICT_MARK = 40,
    parameter int HIGH_MARK     = 56,
    localparam int CNT_W        = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] count_i,
    output wd_level_t        level_o
);

    localparam logic [CNT_W-1:0] LOW_V  = CNT_W'(LOW_MARK);
    localparam logic [CNT_W-1:0] RSTR_V = CNT_W'(RESTRICT_MARK);
    localparam logic [CNT_W-1:0] HIGH_V = CNT_W'(HIGH_MARK);

    always_comb begin
        level_o.at_high         = (count_i >= HIGH_V);
        level_o.at_restrict     = (count_i >= RSTR_V);
        level_o.at_or_below_low = (count_i <= LOW_V);
    end

endmodule

// File: rtl/wdrain_mode_fsm.sv
module wdrain_mode_fsm
    import wdrain_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wd_level_t level_i,
    output wd_mode_e  state_o,
    output wd_mode_e  next_o
);

    wd_mode_e state_q;
    wd_mode_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_READ;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_READ: begin
                if (level_i.at_high) begin
                    state_d = MODE_DRAIN;
                end else if (level_i.at_restrict) begin
                    state_d = MODE_SINGLETON;
                end
            end
            MODE_SINGLETON: begin
                if (level_i.at_high) begin
                    state_d = MODE_DRAIN;
                end else if (!level_i.at_restrict) begin
                    state_d = MODE_READ;
                end
            end
            MODE_DRAIN: begin
                if (level_i.at_or_below_low) begin
                    state_d = MODE_READ;
                end
            end
            default: state_d = MODE_READ;
        endcase
    end

    assign state_o = state_q;
    assign next_o  = state_d;

endmodule

// File: rtl/wdrain_out_reg.sv
module wdrain_out_reg
    import wdrain_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  wd_mode_e next_i,
    input  logic     single_pend_i,
    output logic     drain_o,
    output logic     sonly_o,
    output logic     ren_o
);

    logic drain_d;
    logic sonly_d;
    logic ren_d;

    always_comb begin
        drain_d = 1'b0;
        sonly_d = 1'b0;
        ren_d   = 1'b1;
        unique case (next_i)
            MODE_READ: begin
                ren_d = 1'b1;
            end
            MODE_SINGLETON: begin
                sonly_d = 1'b1;
                ren_d   = single_pend_i;
            end
            MODE_DRAIN: begin
                drain_d = 1'b1;
                ren_d   = 1'b0;
            end
            default: ren_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drain_o <= 1'b0;
            sonly_o <= 1'b0;
            ren_o   <= 1'b1;
        end else begin
            drain_o <= drain_d;
            sonly_o <= sonly_d;
            ren_o   <= ren_d;
        end
    end

endmodule

// File: rtl/wdrain_ctrl.sv
module wdrain_ctrl
    import wdrain_pkg::*;
#(
    parameter int DEPTH         = 64,
    parameter int LOW_MARK      = 16,
    parameter int RESTRICT_MARK = 40,
    parameter int HIGH_MARK     = 56,
    localparam int CNT_W        = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] wq_count,
    input  logic             single_grp_pending,
    output logic [1:0]       mode_o,
    output logic             drain_writes,
    output logic             singleton_only,
    output logic             read_enable
);

    wd_level_t level;
    wd_mode_e  state;
    wd_mode_e  next_state;

    wdrain_level_cmp #(
        .DEPTH        (DEPTH),
        .LOW_MARK     (LOW_MARK),
        .RESTRICT_MARK(RESTRICT_MARK),
        .HIGH_MARK    (HIGH_MARK)
    ) u_cmp (
        .count_i(wq_count),
        .level_o(level)
    );

    wdrain_mode_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(level),
        .state_o(state),
        .next_o (next_state)
    );

    wdrain_out_reg u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .next_i       (next_state),
        .single_pend_i(single_grp_pending),
        .drain_o      (drain_writes),
        .sonly_o      (singleton_only),
        .ren_o        (read_enable)
    );

    assign mode_o = state;

endmodule

// File: rtl/wdrain_checker.sv
module wdrain_checker #(
    parameter int DEPTH         = 64,
    parameter int LOW_MARK      = 16,
    parameter int RESTRICT_MARK = 40,
    parameter int HIGH_MARK     = 56,
    localparam int CNT_W        = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] wq_count,
    input logic             single_grp_pending,
    input logic [1:0]       mode_o,
    input logic             drain_writes,
    input logic             singleton_only,
    input logic             read_enable
);

    logic cnt_high;
    logic cnt_band;
    logic cnt_low;

    assign cnt_high = (int'(wq_count) >= HIGH_MARK);
    assign cnt_band = (int'(wq_count) >= RESTRICT_MARK) && !cnt_high;
    assign cnt_low  = (int'(wq_count) <= LOW_MARK);

    p_enter_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_writes && cnt_high) |=> (drain_writes && mode_o == 2'd2));

    p_hold_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_writes && !cnt_low) |=> drain_writes);

    p_exit_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_writes && cnt_low) |=> (mode_o == 2'd0 && !singleton_only));

    p_enter_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_writes && cnt_band) |=> (singleton_only && mode_o == 2'd1));

    p_drain_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drain_writes |-> !read_enable);

    p_single_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (singleton_only && $past(rst_n)) |-> (read_enable == $past(single_grp_pending)));

    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drain_writes, singleton_only}));

    p_mode_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);

endmodule

bind wdrain_ctrl wdrain_checker #(
    .DEPTH        (DEPTH),
    .LOW_MARK     (LOW_MARK),
    .RESTRICT_MARK(RESTRICT_MARK),
    .HIGH_MARK    (HIGH_MARK)
) u_wdrain_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .wq_count          (wq_count),
    .single_grp_pending(single_grp_pending),
    .mode_o            (mode_o),
    .drain_writes      (drain_writes),
    .singleton_only    (singleton_only),
    .read_enable       (read_enable)
);

// File: tb/test_wdrain_ctrl.sv
module test_wdrain_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] wq_count = '0;
    logic       single_grp_pending = 1'b0;
    logic [1:0] mode_o;
    logic       drain_writes;
    logic       singleton_only;
    logic       read_enable;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdrain_ctrl i_wdrain_ctrl (
        .clk               (clk),
        .rst_n             (rst_n),
        .wq_count          (wq_count),
        .single_grp_pending(single_grp_pending),
        .mode_o            (mode_o),
        .drain_writes      (drain_writes),
        .singleton_only    (singleton_only),
        .read_enable       (read_enable)
    );

    // Vector fields: count, pending, expected mode, drain, singleton_only, read_enable, requirement number
    localparam int NV = 16;
    localparam int VEC [NV][7] = '{
        '{10, 0, 0, 0, 0, 1, 6},   // R6 pending ignored in READ
        '{39, 1, 0, 0, 0, 1, 4},   // R4 one below restrict mark
        '{40, 0, 1, 0, 1, 0, 4},   // R4 on restrict mark, R6 no singleton
        '{45, 1, 1, 0, 1, 1, 6},   // R6 singleton pending
        '{39, 1, 0, 0, 0, 1, 4},   // R4 back to READ
        '{50, 1, 1, 0, 1, 1, 4},
        '{55, 0, 1, 0, 1, 0, 6},   // R6 one below high mark
        '{56, 1, 2, 1, 0, 0, 2},   // R2 on high mark from SINGLETON, R5
        '{45, 1, 2, 1, 0, 0, 3},   // R3 hysteresis inside band
        '{17, 1, 2, 1, 0, 0, 3},   // R3 one above low mark
        '{16, 0, 0, 0, 0, 1, 3},   // R3 on low mark
        '{60, 1, 2, 1, 0, 0, 2},   // R2 direct from READ
        '{64, 0, 2, 1, 0, 0, 5},   // R5 full queue
        '{ 0, 0, 0, 0, 0, 1, 3},
        '{40, 1, 1, 0, 1, 1, 7},   // R7 encoding of SINGLETON
        '{ 5, 1, 0, 0, 0, 1, 7}    // R7 encoding of READ
    };

    task automatic check(input int req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: {mode,drain,sonly,ren} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic apply(input int cnt, input logic pend);
        @(negedge clk);
        wq_count = 7'(cnt);
        single_grp_pending = pend;
        @(posedge clk);
        #1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000 && !done) begin
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        // R1 reset state while held
        repeat (2) @(posedge clk);
        #1;
        check(1, {mode_o, drain_writes, singleton_only, read_enable}, 5'b00_001);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(1, {mode_o, drain_writes, singleton_only, read_enable}, 5'b00_001);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][0], VEC[i][1] != 0);
            check(VEC[i][6], {mode_o, drain_writes, singleton_only, read_enable},
                  {2'(VEC[i][2]), 1'(VEC[i][3]), 1'(VEC[i][4]), 1'(VEC[i][5])});
        end

        // R2 from SINGLETON straight to a full queue
        apply(44, 1);
        check(4, {mode_o, drain_writes, singleton_only, read_enable}, 5'b01_011);
        apply(64, 1);
        check(2, {mode_o, drain_writes, singleton_only, read_enable}, 5'b10_100);

        // R6 pending toggles within SINGLETON after drain exits via READ
        apply(0, 0);
        apply(41, 0);
        check(6, {mode_o, drain_writes, singleton_only, read_enable}, 5'b01_010);
        apply(41, 1);
        check(6, {mode_o, drain_writes, singleton_only, read_enable}, 5'b01_011);

        // R1 reset in the middle of a drain
        apply(58, 0);
        check(2, {mode_o, drain_writes, singleton_only, read_enable}, 5'b10_100);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(1, {mode_o, drain_writes, singleton_only, read_enable}, 5'b00_001);
        @(negedge clk);
        wq_count = 7'd30;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(1, {mode_o, drain_writes, singleton_only, read_enable}, 5'b00_001);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule